// File: doc/BRIEF.md
# DMA Register Port Interface

This block is the processor-facing register file of a DMA controller. Software reaches it through two I/O ports. A write to the select port latches a register number. The data port then reads or writes the register that number names. The file holds five 16-bit registers: source address, destination address, rate prescaler, transfer length and probe address. It also holds an 8-bit control register and a read-only status byte. Every register value is driven continuously to the transfer engine, which lies outside this block.

A 16-bit register moves as two byte accesses on the data port, low byte first and then high byte. A single toggle tracks which byte comes next, and writing the select port returns it to the low byte. The status byte carries one flag, the probe hit. The engine sets it with a one-cycle pulse, and a data-port read of the status register clears it.

The bus uses single-cycle read and write strobes with a 16-bit port address and 8-bit data. Read data is combinational while the read strobe is high. The side effects of a read, the toggle flip and the status clear, take place at the clock edge that ends the strobe.

Top module: `dmareg_port`

## Requirements
- R1: After reset, all five 16-bit registers and the control register are 0, and a data-port read returns 0xFF because no register is selected.
- R2: A write to port 0xFC3B latches the data byte as the register number and sets the byte toggle to the low byte.
- R3: With register 0xA1 (source), 0xA2 (destination), 0xA3 (prescaler), 0xA4 (length) or 0xA5 (probe) selected, a data-port write to 0xFD3B updates only the low byte when the toggle is low and only the high byte when it is high; the new value appears on the matching output the cycle after the strobe.
- R4: Each data-port read or write to a 16-bit register flips the toggle, shared between reads and writes, so a third access after a select targets the low byte again; a read returns the low byte when the toggle is low and the high byte when it is high.
- R5: Control register 0xA0 stores write bits 4:0 and reads back {000, bits 4:0}; bits 1:0 drive mode_o, bit 2 drives dst_is_io_o, bit 3 drives src_is_io_o, bit 4 drives probe_on_dst_o.
- R6: Status register 0xA6 reads as {probe hit, 7'b0}; a pulse on probe_hit_i sets the flag, a read clears it, and data-port writes to it have no effect.
- R7: If probe_hit_i is high in the same cycle as a status read, that read returns the old flag and the flag is set afterwards.
- R8: With any other register number selected, data-port reads return 0xFF and data-port writes change no register.
- R9: Strobes at any port address other than 0xFC3B and 0xFD3B change neither the selection nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 8 | Write data |
| io_wr_i | input | 1 | Write strobe, one cycle per access |
| io_rd_i | input | 1 | Read strobe, one cycle per access |
| io_rdata_o | output | 8 | Read data, valid during a data-port read strobe; 0xFF otherwise |
| probe_hit_i | input | 1 | Set pulse for the probe-hit flag from the transfer engine |
| src_addr_o | output | 16 | Source address register |
| dst_addr_o | output | 16 | Destination address register |
| prescale_o | output | 16 | Rate prescaler register |
| length_o | output | 16 | Transfer length register |
| probe_addr_o | output | 16 | Probe address register |
| mode_o | output | 2 | Control bits 1:0, transfer mode |
| dst_is_io_o | output | 1 | Control bit 2, destination is I/O |
| src_is_io_o | output | 1 | Control bit 3, source is I/O |
| probe_on_dst_o | output | 1 | Control bit 4, probe watches the destination |

## Verification
A toggle left in the wrong state sends the next byte to the wrong half of a register. That shows on the register's output one cycle after the write strobe, and on io_rdata_o during the very next read. A wrong latched register number shows up either as 0xFF on read or as a write landing on a different output bus. A status flag that fails to set, or fails to clear, shows on the next status read, so the bench reads twice in a row around every probe pulse, including a pulse that coincides with a read.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int unsigned NUM_WORDS = 5;
  localparam int unsigned CTRL_W    = 5;
  // offsets from the register-number base
  localparam int unsigned CTRL_OFS  = 0;
  localparam int unsigned WORD_OFS  = 1;
  localparam int unsigned STAT_OFS  = WORD_OFS + NUM_WORDS;

  typedef struct packed {
    logic       probe_dst;
    logic       src_io;
    logic       dst_io;
    logic [1:0] mode;
  } ctrl_t;
endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode #(
  parameter logic [15:0] SEL_ADDR  = 16'hFC3B,
  parameter logic [15:0] DATA_ADDR = 16'hFD3B
) (
  input  logic [15:0] addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic        sel_wr_o,
  output logic        data_wr_o,
  output logic        data_rd_o
);
  logic at_sel, at_data;
  assign at_sel    = (addr_i == SEL_ADDR);
  assign at_data   = (addr_i == DATA_ADDR);
  assign sel_wr_o  = at_sel & wr_i;
  assign data_wr_o = at_data & wr_i;
  assign data_rd_o = at_data & rd_i;
endmodule

// File: rtl/dmareg_word16.sv
module dmareg_word16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        hi_i,
  input  logic [7:0]  wdata_i,
  output logic [15:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_o <= '0;
    else if (wr_i && hi_i)  q_o[15:8] <= wdata_i;
    else if (wr_i)          q_o[7:0]  <= wdata_i;
  end

  // R3: a low-byte write leaves the high byte alone, and the reverse
  assert_low_keeps_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hi_i) |=> (q_o[15:8] == $past(q_o[15:8])));
  assert_high_keeps_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hi_i) |=> (q_o[7:0] == $past(q_o[7:0])));
endmodule

// File: rtl/dmareg_status.sv
module dmareg_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over a coincident clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assert_hit_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  assert_holds_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/dmareg_port.sv
module dmareg_port
  import dmareg_pkg::*;
#(
  parameter logic [15:0] SEL_ADDR  = 16'hFC3B,
  parameter logic [15:0] DATA_ADDR = 16'hFD3B,
  parameter logic [7:0]  IDX_BASE  = 8'hA0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] io_addr_i,
  input  logic [7:0]  io_wdata_i,
  input  logic        io_wr_i,
  input  logic        io_rd_i,
  output logic [7:0]  io_rdata_o,
  input  logic        probe_hit_i,
  output logic [15:0] src_addr_o,
  output logic [15:0] dst_addr_o,
  output logic [15:0] prescale_o,
  output logic [15:0] length_o,
  output logic [15:0] probe_addr_o,
  output logic [1:0]  mode_o,
  output logic        dst_is_io_o,
  output logic        src_is_io_o,
  output logic        probe_on_dst_o
);
  localparam logic [7:0] CTRL_IDX = 8'(IDX_BASE + 8'(CTRL_OFS));
  localparam logic [7:0] STAT_IDX = 8'(IDX_BASE + 8'(STAT_OFS));

  logic        sel_wr, data_wr, data_rd;
  logic [7:0]  idx_q;
  logic        hi_q;
  ctrl_t       ctrl_q;
  logic        flag;
  logic [15:0] word_q   [NUM_WORDS];
  logic [NUM_WORDS-1:0] word_sel;
  logic        ctrl_sel, stat_sel, is_word, known;
  logic [7:0]  rd_byte;

  dmareg_decode #(.SEL_ADDR(SEL_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
    .addr_i(io_addr_i), .wr_i(io_wr_i), .rd_i(io_rd_i),
    .sel_wr_o(sel_wr), .data_wr_o(data_wr), .data_rd_o(data_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      hi_q  <= 1'b0;
    end else if (sel_wr) begin
      idx_q <= io_wdata_i;
      hi_q  <= 1'b0;
    end else if ((data_wr || data_rd) && is_word) begin
      hi_q  <= ~hi_q;
    end
  end

  assign ctrl_sel = (idx_q == CTRL_IDX);
  assign stat_sel = (idx_q == STAT_IDX);
  assign is_word  = |word_sel;
  assign known    = ctrl_sel | stat_sel | is_word;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam logic [7:0] WIDX = 8'(IDX_BASE + 8'(WORD_OFS + i));
    assign word_sel[i] = (idx_q == WIDX);
    dmareg_word16 u_word (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_i(data_wr && word_sel[i]), .hi_i(hi_q),
      .wdata_i(io_wdata_i), .q_o(word_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ctrl_q <= '0;
    else if (data_wr && ctrl_sel) ctrl_q <= ctrl_t'(io_wdata_i[CTRL_W-1:0]);
  end

  dmareg_status u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(probe_hit_i), .clr_i(data_rd && stat_sel),
    .flag_o(flag)
  );

  always_comb begin
    rd_byte = 8'hFF;
    if (ctrl_sel)      rd_byte = {{(8-CTRL_W){1'b0}}, ctrl_q};
    else if (stat_sel) rd_byte = {flag, 7'b0};
    else begin
      for (int i = 0; i < NUM_WORDS; i++)
        if (word_sel[i]) rd_byte = hi_q ? word_q[i][15:8] : word_q[i][7:0];
    end
  end

  assign io_rdata_o     = data_rd ? rd_byte : 8'hFF;
  assign src_addr_o     = word_q[0];
  assign dst_addr_o     = word_q[1];
  assign prescale_o     = word_q[2];
  assign length_o       = word_q[3];
  assign probe_addr_o   = word_q[4];
  assign mode_o         = ctrl_q.mode;
  assign dst_is_io_o    = ctrl_q.dst_io;
  assign src_is_io_o    = ctrl_q.src_io;
  assign probe_on_dst_o = ctrl_q.probe_dst;

  assert_sel_clears_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> !hi_q);
  assert_toggle_flips_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((data_wr || data_rd) && is_word) |=> (hi_q != $past(hi_q)));
  assert_ctrl_rsvd_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && ctrl_sel) |-> (io_rdata_o[7:5] == 3'b000));
  assert_unknown_reads_ff_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !known) |-> (io_rdata_o == 8'hFF));
  assert_idle_keeps_index_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr |=> $stable(idx_q));
endmodule

// File: tb/tb_dmareg_port.sv
module tb_dmareg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0, hit = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] src, dst, pre, len, prb;
  logic [1:0]  mode;
  logic        dio, sio, pdst;

  int checks = 0, errors = 0;
  logic [15:0] exp_w [5];
  logic [4:0]  exp_c;

  localparam logic [15:0] SELP = 16'hFC3B, DATP = 16'hFD3B;

  always #4 clk = ~clk;

  dmareg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wdata_i(wdata),
    .io_wr_i(wr), .io_rd_i(rd), .io_rdata_o(rdata), .probe_hit_i(hit),
    .src_addr_o(src), .dst_addr_o(dst), .prescale_o(pre), .length_o(len),
    .probe_addr_o(prb), .mode_o(mode), .dst_is_io_o(dio), .src_is_io_o(sio),
    .probe_on_dst_o(pdst)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wout(input int i);
    case (i)
      0: return src;
      1: return dst;
      2: return pre;
      3: return len;
      default: return prb;
    endcase
  endfunction

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d, input logic h = 1'b0);
    @(negedge clk); addr = a; rd = 1'b1; hit = h;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0; hit = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 5; i++) chk(req, wout(i), exp_w[i]);
    chk(req, {11'b0, pdst, sio, dio, mode}, {11'b0, exp_c});
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b, lo, hi;
    for (int i = 0; i < 5; i++) exp_w[i] = '0;
    exp_c = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_all("R1");
    io_rd(DATP, b);
    chk("R1 read with nothing selected", {8'h0, b}, 16'h00FF);

    // R3 R4: sweep of the five 16-bit registers over several patterns
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 5; i++) begin
        logic [15:0] v;
        v = 16'((p * 16'h3A17) ^ (16'h1111 * (i + 1)) ^ (p[0] ? 16'hFFFF : 16'h0000));
        io_wr(SELP, 8'(8'hA1 + i));
        io_wr(DATP, v[7:0]);
        exp_w[i][7:0] = v[7:0];
        chk("R3 low byte only", wout(i), exp_w[i]);
        io_wr(DATP, v[15:8]);
        exp_w[i] = v;
        chk("R3 high byte", wout(i), v);
        io_rd(DATP, lo);
        io_rd(DATP, hi);
        chk("R4 read back low then high", {hi, lo}, v);
      end
      check_all("R3 all outputs");
    end

    // R4: third access returns to the low byte; toggle shared by reads and writes
    io_wr(SELP, 8'hA2);
    io_wr(DATP, 8'h12);
    io_wr(DATP, 8'h34);
    io_wr(DATP, 8'h56);
    exp_w[1] = 16'h3456;
    chk("R4 third write hits low byte", dst, 16'h3456);
    io_rd(DATP, b);
    chk("R4 read after three writes is high byte", {8'h0, b}, 16'h0034);
    io_wr(SELP, 8'hA2);
    io_rd(DATP, b);
    io_wr(DATP, 8'h9A);
    exp_w[1] = 16'h9A56;
    chk("R4 write after read targets high", dst, 16'h9A56);
    chk("R4 first read after select is low", {8'h0, b}, 16'h0056);

    // R2: select resets toggle mid-word
    io_wr(SELP, 8'hA4);
    io_wr(DATP, 8'hC3);
    io_wr(SELP, 8'hA4);
    io_wr(DATP, 8'h5D);
    exp_w[3][7:0] = 8'h5D;
    chk("R2 reselect restarts at low byte", len, exp_w[3]);

    // R5: exhaustive control byte sweep
    for (int v = 0; v < 256; v++) begin
      io_wr(SELP, 8'hA0);
      io_wr(DATP, 8'(v));
      exp_c = 5'(v);
      chk("R5 control fields", {11'b0, pdst, sio, dio, mode}, {11'b0, exp_c});
      io_rd(DATP, b);
      chk("R5 control readback", {8'h0, b}, 16'(v & 8'h1F));
    end
    check_all("R5 words untouched");

    // R6: status set, clear, write ignored
    io_wr(SELP, 8'hA6);
    io_rd(DATP, b);
    chk("R6 status idle", {8'h0, b}, 16'h0000);
    @(negedge clk); hit = 1'b1;
    @(negedge clk); hit = 1'b0;
    io_rd(DATP, b);
    chk("R6 status after hit", {8'h0, b}, 16'h0080);
    io_rd(DATP, b);
    chk("R6 cleared by read", {8'h0, b}, 16'h0000);
    io_wr(DATP, 8'hFF);
    io_rd(DATP, b);
    chk("R6 write ignored", {8'h0, b}, 16'h0000);
    check_all("R6 write to status");

    // R7: hit coincident with read
    io_rd(DATP, b, 1'b1);
    chk("R7 coincident read shows old flag", {8'h0, b}, 16'h0000);
    io_rd(DATP, b);
    chk("R7 flag set after coincident read", {8'h0, b}, 16'h0080);
    @(negedge clk); hit = 1'b1;
    @(negedge clk); hit = 1'b0;
    io_rd(DATP, b, 1'b1);
    chk("R7 set flag read with hit", {8'h0, b}, 16'h0080);
    io_rd(DATP, b);
    chk("R7 flag survives", {8'h0, b}, 16'h0080);
    io_rd(DATP, b);
    chk("R7 then clears", {8'h0, b}, 16'h0000);

    // R8: unknown register numbers
    foreach (exp_w[k]) ;
    for (int u = 0; u < 256; u++) begin
      if (u >= 8'hA0 && u <= 8'hA6) continue;
      io_wr(SELP, 8'(u));
      io_rd(DATP, b);
      chk("R8 unknown read", {8'h0, b}, 16'h00FF);
      io_wr(DATP, 8'(u ^ 8'h5A));
    end
    check_all("R8 writes ignored");

    // R9: other port addresses
    io_wr(SELP, 8'hA1);
    io_wr(16'hFC3C, 8'hA3);
    io_wr(16'hFD3A, 8'h77);
    io_wr(16'hFE3B, 8'h66);
    io_wr(16'h003B, 8'h55);
    check_all("R9 stray writes");
    io_rd(16'hFC3B, b);
    chk("R9 select port read", {8'h0, b}, 16'h00FF);
    io_wr(DATP, 8'hE1);
    exp_w[0][7:0] = 8'hE1;
    chk("R9 selection kept", src, exp_w[0]);
    check_all("R9 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule